// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two WIDTH-bit two's complement numbers over several clock cycles. It uses radix-2 Booth recoding and retires one multiplier bit per cycle. A one-cycle `start` pulse latches both operands while the unit is idle. The unit then holds `busy` for WIDTH cycles and raises `done` for a single cycle. On that cycle the full 2·WIDTH-bit signed product is present on `product`.

Each step looks at the current low bit of the shifting multiplier together with the bit retired on the step before. On the first step that earlier bit is an implied zero.

- Entering a run of ones subtracts the multiplicand from a guard-extended upper accumulator.
- Leaving a run of ones adds the multiplicand.
- Staying inside a run of ones, or inside a run of zeros, adds nothing.

After that, the accumulator and multiplier pair shift right arithmetically by one place. Negative operands therefore need no conversion before the multiply and no negation after it.

The product register keeps its value between completions. Software-free logic around the block can therefore read the result at any time after `done`. A `start` raised while the unit is busy is dropped.

Top module: `booth_mult`

## Requirements
- R1: While reset is held and after it is released, `busy` and `done` are 0 and `product` is all zeros until the first operation completes.
- R2: A `start` sampled high while `busy` is low captures `multiplicand` and `multiplier` on that clock edge, and `busy` is high on the following cycle.
- R3: `done` rises in the cycle after the WIDTH-th clock edge that follows the accepting edge. It stays high for exactly one cycle, and `busy` is never high at the same time as `done`.
- R4: When `done` is high, `product` equals the signed two's complement product of the captured operands over all 2·WIDTH bits. This includes the most negative value squared, which gives +2^(2·WIDTH-2) (for example +256 when WIDTH is 5).
- R5: The recoding uses the pair (current bit, previous bit) with an implied 0 below bit 0. The pair (1,0) subtracts the multiplicand, (0,1) adds it, and (0,0) or (1,1) add nothing. Typical results: -6 × -2 = +12, an all-ones multiplier gives the negated multiplicand, and alternating multiplier patterns give the exact product.
- R6: A `start` raised while `busy` is high is ignored. It neither changes the operands of the running operation nor changes when `done` arrives.
- R7: `product` changes only in the cycle in which `done` is high. Otherwise it holds its value, including while the next operation is running.
- R8: A `start` raised in the cycle where `done` is high is accepted, so operations can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an operation when idle |
| multiplicand | input | WIDTH | Signed multiplicand, captured on an accepted start |
| multiplier | input | WIDTH | Signed multiplier, captured on an accepted start |
| busy | output | 1 | High while recoding steps are in progress |
| done | output | 1 | One-cycle pulse when the product is updated |
| product | output | 2·WIDTH | Signed product of the last completed operation |

## Verification
The bench sweeps every operand pair at WIDTH 5. This reaches the most negative value squared, which a design whose accumulator lacks a guard bit would return as a negative number. The sweep also covers all-ones and alternating multipliers. A swapped add/subtract choice or a missing implied zero below bit 0 would corrupt these, typically leaving the result off by the multiplicand. Latency is counted on every operation, so an off-by-one step counter shows up as an early or late `done` and a wrongly scaled product. A start pulse during busy and a start in the `done` cycle check that the operands are not overwritten mid-run and that back-to-back operation is not dropped.

// File: rtl/booth_mult_pkg.sv
package booth_mult_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_mult_pkg::*;
(
  input  logic      cur_bit,
  input  logic      prev_bit,
  output booth_op_e op
);
  always_comb begin
    unique case ({cur_bit, prev_bit})
      2'b10:   op = OP_SUB;
      2'b01:   op = OP_ADD;
      default: op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_mult_pkg::*;
#(
  parameter int unsigned W = 9
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] addend,
  input  booth_op_e    op,
  output logic [W-1:0] sum
);
  always_comb begin
    unique case (op)
      OP_ADD:  sum = acc + addend;
      OP_SUB:  sum = acc - addend;
      default: sum = acc;
    endcase
  end
endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
  parameter int unsigned STEPS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step_en,
  output logic last_step,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          done_q, done_d;

  assign load      = start & ~busy_q;
  assign step_en   = busy_q;
  assign last_step = busy_q & (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (load) begin
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/booth_mult.sv
module booth_mult
  import booth_mult_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  localparam int unsigned AW = WIDTH + 1;
  localparam int unsigned PW = 2 * WIDTH;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic load, step_en, last_step;

  booth_seq_ctrl #(.STEPS(WIDTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .load      (load),
    .step_en   (step_en),
    .last_step (last_step),
    .busy      (busy),
    .done      (done)
  );

  logic [AW-1:0]    acc_q, acc_d;
  logic [AW-1:0]    mcand_q, mcand_d;
  logic [WIDTH-1:0] mplr_q, mplr_d;
  logic             prev_q, prev_d;
  logic [PW-1:0]    prod_q, prod_d;
  logic [AW-1:0]    sum;
  booth_op_e        op;

  booth_recode u_recode (
    .cur_bit  (mplr_q[0]),
    .prev_bit (prev_q),
    .op       (op)
  );

  booth_addsub #(.W(AW)) u_addsub (
    .acc    (acc_q),
    .addend (mcand_q),
    .op     (op),
    .sum    (sum)
  );

  always_comb begin
    acc_d   = acc_q;
    mcand_d = mcand_q;
    mplr_d  = mplr_q;
    prev_d  = prev_q;
    prod_d  = prod_q;
    if (load) begin
      acc_d   = '0;
      mcand_d = {multiplicand[WIDTH-1], multiplicand};
      mplr_d  = multiplier;
      prev_d  = 1'b0;
    end else if (step_en) begin
      acc_d  = {sum[AW-1], sum[AW-1:1]};
      mplr_d = {sum[0], mplr_q[WIDTH-1:1]};
      prev_d = mplr_q[0];
      if (last_step) prod_d = {acc_d[WIDTH-1:0], mplr_d};
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      acc_q   <= '0;
      mcand_q <= '0;
      mplr_q  <= '0;
      prev_q  <= 1'b0;
      prod_q  <= '0;
    end else begin
      if (load | step_en) begin
        acc_q  <= acc_d;
        mplr_q <= mplr_d;
        prev_q <= prev_d;
      end
      if (load)      mcand_q <= mcand_d;
      if (last_step) prod_q  <= prod_d;
    end
  end

  assign product = prod_q;
endmodule

// File: rtl/booth_mult_chk.sv
module booth_mult_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [WIDTH-1:0]   multiplicand,
  input logic [WIDTH-1:0]   multiplier,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);
  logic signed [WIDTH-1:0]   a_l, b_l;
  logic signed [2*WIDTH-1:0] ref_prod;
  logic [15:0]               cyc;

  assign ref_prod = a_l * b_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_l <= '0;
      b_l <= '0;
      cyc <= '0;
    end else if (start && !busy) begin
      a_l <= multiplicand;
      b_l <= multiplier;
      cyc <= '0;
    end else if (busy) begin
      cyc <= cyc + 16'd1;
    end
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  // R3
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cyc == 16'(WIDTH)));
  // R4
  product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($signed(product) == ref_prod));
  // R7
  product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product));
  // R8
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> busy);
endmodule

bind booth_mult booth_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .multiplicand (multiplicand),
  .multiplier   (multiplier),
  .busy         (busy),
  .done         (done),
  .product      (product)
);

// File: tb/booth_mult_tb.sv
`timescale 1ns/1ps
module booth_mult_tb;
  localparam int W = 5;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [W-1:0]  mcand, mplr;
  logic          busy, done;
  logic [PW-1:0] product;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  booth_mult #(.WIDTH(W)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .multiplicand (mcand),
    .multiplier   (mplr),
    .busy         (busy),
    .done         (done),
    .product      (product)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (lat < 40) begin
      @(negedge clk);
      start = 1'b0;
      lat++;
      if (done) break;
    end
  endtask

  task automatic run_op(input int a, input int b, input bit poke, input string tag);
    int lat;
    int held;
    @(negedge clk);
    mcand = W'(a); mplr = W'(b); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2 busy after start", int'(busy), 1);
    if (poke) begin
      start = 1'b1; mcand = W'(a + 7); mplr = W'(b - 3);
    end
    wait_done(lat);
    lat++;
    check(lat == W + 1, "R3 latency", lat, W + 1);
    check($signed(product) == a * b, tag, int'($signed(product)), a * b);
    held = int'($signed(product));
    @(negedge clk);
    check(done === 1'b0, "R3 done one cycle", int'(done), 0);
    @(negedge clk);
    check(int'($signed(product)) == held, "R7 product held", int'($signed(product)), held);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int lat;
    rst_n = 1'b0; start = 1'b0; mcand = '0; mplr = '0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && product === '0, "R1 reset state", int'(product), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && product === '0, "R1 after release", int'(product), 0);

    // R4 exhaustive sweep
    for (int a = -(1 << (W-1)); a < (1 << (W-1)); a++)
      for (int b = -(1 << (W-1)); b < (1 << (W-1)); b++)
        run_op(a, b, 1'b0, "R4 product");

    // R4 most negative squared
    run_op(-16, -16, 1'b0, "R4 min squared");
    // R5 recoding patterns
    run_op(-6, -2, 1'b0, "R5 run of ones");
    run_op(13, -1, 1'b0, "R5 all ones multiplier");
    run_op(-9, -11, 1'b0, "R5 alternating multiplier");
    run_op(15, 10, 1'b0, "R5 alternating positive");
    // R6 start during busy ignored
    run_op(3, -5, 1'b1, "R6 start ignored");
    run_op(-16, 15, 1'b1, "R6 start ignored extreme");

    // R8 back-to-back start in the done cycle
    @(negedge clk);
    mcand = W'(9); mplr = W'(7); start = 1'b1;
    wait_done(lat);
    mcand = W'(-4); mplr = W'(5); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R8 back-to-back accepted", int'(busy), 1);
    check(int'($signed(product)) == 63, "R7 held during next op", int'($signed(product)), 63);
    wait_done(lat);
    lat++;
    check(lat == W + 1, "R8 back-to-back latency", lat, W + 1);
    check(int'($signed(product)) == -20, "R8 back-to-back product", int'($signed(product)), -20);

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule